// File: doc/BRIEF.md
# Two-Channel Reloading Pulse Generator

This block produces rectangular waveforms on two output pins. Each channel holds two 8-bit reload values, one for the low phase and one for the high phase. An 8-bit down-counter times each phase, so the duty cycle and the period are both programmable. The counters advance on a count-clock tick. Each channel chooses its tick from the system clock divided by 1, 2, 4, 8 or 16, or from a slow tick pulse that arrives on an input pin.

The two channels can be paired in three ways. In split mode they are two separate generators. In wide mode they form one 16-bit generator, where channel 1 supplies the upper byte of each width and channel 0 the lower byte. In chained mode channel 0 runs as a prescaler, and every phase end it produces becomes one count tick for channel 1.

Software programs the block through a small write port: an address, a byte and a strobe. Each channel raises a flag at the end of every full period. A write of one to the flag clears it.

Top module: `pulse_pair_gen`

## Requirements
- R1: After reset both pins are low, both flags are clear, and every register reads as zero, so no channel runs.
- R2: When a channel's run bit goes from 0 to 1, the channel starts in the low phase and loads the low reload value L. With the system-clock tick, the pin goes high L+2 clock edges after the edge that stores the run bit.
- R3: In split mode a channel holds its pin high for (H+1) ticks and low for (L+1) ticks, where H and L are its reload values. Channel 0 uses addresses 0 (low) and 1 (high), and channel 1 uses addresses 2 (low) and 3 (high).
- R4: Address 5 selects the tick: bits [2:0] for channel 0 and bits [6:4] for channel 1. Codes 0 to 4 give one tick every 2^code system clocks. Code 5 uses each cycle that `slow_tick` is high. Codes 6 and 7 give no ticks.
- R5: Mode 1 (address 4 bits [1:0]) is wide mode. The widths become {addr2,addr0}+1 and {addr3,addr1}+1 ticks, and channel 1's run bit, output-enable bit and tick select control the pair. Pin 1 and flag 1 carry the result, while pin 0 stays low and flag 0 is never set.
- R6: Mode 2 is chained mode. Channel 0 runs as in split mode, and each end of one of its phases is one tick for channel 1. Channel 1's own tick select is then ignored.
- R7: A channel's flag is set on the same clock edge that ends its high phase. Writing address 6 clears flag i when data bit i is 1. If a set and a clear fall on the same edge, the set wins.
- R8: A reload value written while the channel is running affects only the phases that begin after the write. The phase already in progress keeps its width.
- R9: Address 4 bit 4 enables pin 0 and bit 5 enables pin 1. A disabled pin stays low while its channel keeps counting and keeps setting its flag.
- R10: Address 4 bit 2 is the run bit for channel 0 and bit 3 for channel 1. Clearing a run bit stops the channel and returns its pin low one clock after the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Slow fixed-period tick pulse, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pulse_out | output | 2 | Waveform pins, bit i belongs to channel i |
| irq_flag | output | 2 | Period-end flags, bit i belongs to channel i |

## Verification
Channel 1's waveform in chained mode is the hardest case to reach, because its tick spacing depends on channel 0's two phase widths and on channel 0's own divider. The bench gives channel 0 equal low and high values so that the spacing is uniform. The expected widths are then products of the two channels' spans and the divider. A reload rewrite is timed from the observed rising edge so that it lands in the middle of a high phase. A flag clear is placed inside a high phase so that the bench can watch the flag rise on exactly the edge where the pin falls.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_WIDE  = 2'd1,
    MODE_CHAIN = 2'd2,
    MODE_RSVD  = 2'd3
  } pair_mode_e;

  localparam int unsigned DIV_TAPS = 5;
  localparam int unsigned SEL_BITS = 3;

endpackage

// File: rtl/ppg_divider.sv
module ppg_divider #(
  parameter int unsigned NDIV = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NDIV-1:0] taps
);

  localparam int unsigned DW = (NDIV > 1) ? NDIV - 1 : 1;
  localparam logic [DW-1:0] DIV_ONE = DW'(1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + DIV_ONE;
  end

  assign taps[0] = 1'b1;

  generate
    for (genvar k = 1; k < NDIV; k++) begin : g_tap
      assign taps[k] = &div_q[k-1:0];

      // R4: a slower tap only fires when every faster tap fires
      p_tap_nested_r4: assert property (@(posedge clk) disable iff (!rst_n)
        taps[k] |-> taps[k-1]);
    end
  endgenerate

endmodule

// File: rtl/ppg_channel.sv
module ppg_channel #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] low_val,
  input  logic [W-1:0] high_val,
  output logic         phase,
  output logic         underflow,
  output logic         period_end
);

  localparam logic [W-1:0] CNT_ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         active_q;
  logic         phase_q;

  // Arithmetic of a phase end: the counter sits at zero when a tick arrives.
  function automatic logic at_floor(input logic [W-1:0] c);
    return c == '0;
  endfunction

  // Reload value for the phase that follows the current one.
  function automatic logic [W-1:0] next_load(input logic cur_phase,
                                             input logic [W-1:0] lo,
                                             input logic [W-1:0] hi);
    return cur_phase ? lo : hi;
  endfunction

  assign underflow  = active_q & tick & at_floor(cnt_q);
  assign period_end = underflow & phase_q;
  assign phase      = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      phase_q  <= 1'b0;
    end else if (!run) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      phase_q  <= 1'b0;
    end else if (!active_q) begin
      active_q <= 1'b1;
      phase_q  <= 1'b0;
      cnt_q    <= low_val;
    end else if (underflow) begin
      phase_q  <= ~phase_q;
      cnt_q    <= next_load(phase_q, low_val, high_val);
    end else if (tick) begin
      cnt_q    <= cnt_q - CNT_ONE;
    end
  end

  // R10: a stopped channel rests in the low phase
  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !phase_q);

  // R2: start-up always enters the low phase with the low reload value
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !active_q) |=> (!phase_q && cnt_q == $past(low_val)));

  // R3: without a tick neither the phase nor the count moves
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && active_q && !tick) |=> ($stable(phase_q) && $stable(cnt_q)));

  // R3: the phase only flips where the counter ran out
  p_flip_on_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && active_q && tick && !at_floor(cnt_q)) |=> $stable(phase_q));

endmodule

// File: rtl/pulse_pair_gen.sv
module pulse_pair_gen #(
  parameter int unsigned CW   = 8,
  parameter int unsigned AW   = 3,
  parameter int unsigned NDIV = ppg_pkg::DIV_TAPS,
  parameter int unsigned SELW = ppg_pkg::SEL_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [1:0]    pulse_out,
  output logic [1:0]    irq_flag
);

  import ppg_pkg::*;

  localparam int unsigned WW       = 2 * CW;
  localparam int unsigned NCH      = 2;
  localparam int unsigned B_RUN0   = 2;
  localparam int unsigned B_OE0    = 4;
  localparam int unsigned SEL1_LSB = 4;

  localparam logic [AW-1:0] A_LOW0  = AW'(0);
  localparam logic [AW-1:0] A_HIGH0 = AW'(1);
  localparam logic [AW-1:0] A_LOW1  = AW'(2);
  localparam logic [AW-1:0] A_HIGH1 = AW'(3);
  localparam logic [AW-1:0] A_CTRL  = AW'(4);
  localparam logic [AW-1:0] A_CSEL  = AW'(5);
  localparam logic [AW-1:0] A_CLR   = AW'(6);

  localparam logic [SELW-1:0] SEL_SLOW = SELW'(NDIV);

  // Register state
  logic [CW-1:0]   low_q  [NCH];
  logic [CW-1:0]   high_q [NCH];
  pair_mode_e      mode_q;
  logic [NCH-1:0]  run_q;
  logic [NCH-1:0]  oe_q;
  logic [SELW-1:0] csel_q [NCH];
  logic [NCH-1:0]  irq_q;

  // Named internal events
  logic [NDIV-1:0] taps;
  logic [NCH-1:0]  sel_tick;
  logic            is_wide;
  logic            is_chain;
  logic            run_c0, run_c1, run_w;
  logic            tick_c0, tick_c1;
  logic            ph_c0, ph_c1, ph_w;
  logic            uf_c0, uf_c1, uf_w;
  logic            pe_c0, pe_c1, pe_w;
  logic [NCH-1:0]  pin_phase;
  logic [NCH-1:0]  pend;
  logic [NCH-1:0]  clr_req;
  logic            unused_uf;

  // Tick selection: divider tap, slow input, or nothing.
  function automatic logic pick_tick(input logic [SELW-1:0] sel,
                                     input logic [NDIV-1:0] tp,
                                     input logic slow);
    if (sel < SEL_SLOW)       return tp[sel];
    else if (sel == SEL_SLOW) return slow;
    else                      return 1'b0;
  endfunction

  // Wide-mode width: channel 1 supplies the upper byte.
  function automatic logic [WW-1:0] join_bytes(input logic [CW-1:0] upper,
                                               input logic [CW-1:0] lower);
    return {upper, lower};
  endfunction

  // Register write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        low_q[i]  <= '0;
        high_q[i] <= '0;
        csel_q[i] <= '0;
      end
      mode_q <= MODE_SPLIT;
      run_q  <= '0;
      oe_q   <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_LOW0:  low_q[0]  <= wr_data;
        A_HIGH0: high_q[0] <= wr_data;
        A_LOW1:  low_q[1]  <= wr_data;
        A_HIGH1: high_q[1] <= wr_data;
        A_CTRL: begin
          mode_q <= pair_mode_e'(wr_data[1:0]);
          run_q  <= wr_data[B_RUN0 +: NCH];
          oe_q   <= wr_data[B_OE0 +: NCH];
        end
        A_CSEL: begin
          csel_q[0] <= wr_data[SELW-1:0];
          csel_q[1] <= wr_data[SEL1_LSB +: SELW];
        end
        default: ;
      endcase
    end
  end

  ppg_divider #(.NDIV(NDIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .taps  (taps)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_sel
      assign sel_tick[i] = pick_tick(csel_q[i], taps, slow_tick);
    end
  endgenerate

  // Pairing
  assign is_wide  = (mode_q == MODE_WIDE);
  assign is_chain = (mode_q == MODE_CHAIN);
  assign run_c0   = run_q[0] & ~is_wide;
  assign run_c1   = run_q[1] & ~is_wide;
  assign run_w    = run_q[1] &  is_wide;
  assign tick_c0  = sel_tick[0];
  assign tick_c1  = is_chain ? uf_c0 : sel_tick[1];

  ppg_channel #(.W(CW)) u_ch0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_c0),
    .tick       (tick_c0),
    .low_val    (low_q[0]),
    .high_val   (high_q[0]),
    .phase      (ph_c0),
    .underflow  (uf_c0),
    .period_end (pe_c0)
  );

  ppg_channel #(.W(CW)) u_ch1 (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_c1),
    .tick       (tick_c1),
    .low_val    (low_q[1]),
    .high_val   (high_q[1]),
    .phase      (ph_c1),
    .underflow  (uf_c1),
    .period_end (pe_c1)
  );

  ppg_channel #(.W(WW)) u_wide (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_w),
    .tick       (sel_tick[1]),
    .low_val    (join_bytes(low_q[1], low_q[0])),
    .high_val   (join_bytes(high_q[1], high_q[0])),
    .phase      (ph_w),
    .underflow  (uf_w),
    .period_end (pe_w)
  );

  assign unused_uf = uf_c1 ^ uf_w;

  // Pin routing and period events
  assign pin_phase[0] = is_wide ? 1'b0 : ph_c0;
  assign pin_phase[1] = is_wide ? ph_w : ph_c1;
  assign pend[0]      = is_wide ? 1'b0 : pe_c0;
  assign pend[1]      = is_wide ? pe_w : pe_c1;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_pin
      assign pulse_out[i] = oe_q[i] & pin_phase[i];
      assign clr_req[i]   = wr_en & (wr_addr == A_CLR) & wr_data[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          irq_q[i] <= 1'b0;
        else if (pend[i])    irq_q[i] <= 1'b1;
        else if (clr_req[i]) irq_q[i] <= 1'b0;
      end

      // R7: a flag only rises after a period boundary of its own channel
      p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q[i]) |-> $past(pend[i]));

      // R7: a clear with no competing boundary empties the flag
      p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req[i] && !pend[i]) |=> !irq_q[i]);

      // R7: a boundary always leaves the flag set
      p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend[i] |=> irq_q[i]);
    end
  endgenerate

  assign irq_flag = irq_q;

  // R5: the lower pin is silent while the pair is joined
  p_wide_pin0_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_wide |-> (!pulse_out[0] && !pend[0]));

  // R6: in chained mode channel 1 advances only on a channel 0 phase end
  p_chain_tick_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_chain && run_c1 && $stable(is_chain) && $changed(ph_c1) && $past(run_c1))
      |-> $past(uf_c0));

endmodule

// File: tb/pulse_pair_gen_bench.sv
module pulse_pair_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] pulse_out;
  logic [1:0] irq_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pulse_pair_gen u_pulse_pair_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pulse_out (pulse_out),
    .irq_flag  (irq_flag)
  );

  // Slow tick: one clock high every 7 clocks
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      slow_tick = (ph == 6);
      ph = (ph == 6) ? 0 : ph + 1;
    end
  end

  // Phase span in system clocks: (reload + 1) ticks of 2^sel clocks each
  function automatic int span(input int reload, input int sel);
    return (reload + 1) * (1 << sel);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(input int pin);
    while (pulse_out[pin]) @(negedge clk);
    while (!pulse_out[pin]) @(negedge clk);
  endtask

  task automatic measure(input int pin, output int hi, output int lo);
    wait_rise(pin);
    hi = 0;
    while (pulse_out[pin]) begin hi++; @(negedge clk); end
    lo = 0;
    while (!pulse_out[pin]) begin lo++; @(negedge clk); end
  endtask

  task automatic count_high(input int pin, input int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (pulse_out[pin]) n++;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int hi, lo, n, c;
    logic prev;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 pins", pulse_out, 0);
    check("R1 flags", irq_flag, 0);
    count_high(0, 20, n);
    check("R1 idle pin0", n, 0);

    // R2: start in low phase, first rise L+2 edges after the run write
    wr(3'd5, 8'h00);
    wr(3'd0, 8'd3);
    wr(3'd1, 8'd1);
    wr(3'd4, 8'h14);
    c = 0;
    while (!pulse_out[0]) begin @(negedge clk); c++; end
    check("R2 first rise", c, 5);
    wr(3'd4, 8'h00);

    // R3/R4: sweep of widths and dividers on channel 0
    for (int sel = 0; sel < 3; sel++) begin
      for (int li = 0; li < 4; li++) begin
        for (int hj = 0; hj < 3; hj++) begin
          int lv, hv;
          lv = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 3 : 7;
          hv = (hj == 0) ? 0 : (hj == 1) ? 2 : 5;
          wr(3'd5, 8'(sel));
          wr(3'd0, 8'(lv));
          wr(3'd1, 8'(hv));
          wr(3'd4, 8'h14);
          measure(0, hi, lo);
          check("R3 R4 sweep high", hi, span(hv, sel));
          check("R3 R4 sweep low", lo, span(lv, sel));
          wr(3'd4, 8'h00);
        end
      end
    end

    // R3: both channels independent, different dividers
    wr(3'd5, 8'h31);
    wr(3'd0, 8'd4);
    wr(3'd1, 8'd0);
    wr(3'd2, 8'd2);
    wr(3'd3, 8'd1);
    wr(3'd4, 8'h3C);
    measure(1, hi, lo);
    check("R3 ch1 high", hi, span(1, 3));
    check("R3 ch1 low", lo, span(2, 3));
    measure(0, hi, lo);
    check("R3 ch0 high", hi, span(0, 1));
    check("R3 ch0 low", lo, span(4, 1));
    wr(3'd4, 8'h00);

    // R4: divide by 16
    wr(3'd5, 8'h04);
    wr(3'd0, 8'd0);
    wr(3'd1, 8'd1);
    wr(3'd4, 8'h14);
    measure(0, hi, lo);
    check("R4 div16 high", hi, span(1, 4));
    check("R4 div16 low", lo, span(0, 4));
    wr(3'd4, 8'h00);

    // R4: slow tick every 7 clocks
    wr(3'd5, 8'h05);
    wr(3'd0, 8'd1);
    wr(3'd1, 8'd2);
    wr(3'd4, 8'h14);
    measure(0, hi, lo);
    check("R4 slow high", hi, 3 * 7);
    check("R4 slow low", lo, 2 * 7);
    wr(3'd4, 8'h00);

    // R4: code 6 gives no ticks, pin never rises
    wr(3'd5, 8'h06);
    wr(3'd0, 8'd0);
    wr(3'd4, 8'h14);
    count_high(0, 100, n);
    check("R4 no tick", n, 0);
    wr(3'd4, 8'h00);

    // R8: reload rewrite in the middle of a high phase
    wr(3'd5, 8'h00);
    wr(3'd0, 8'd2);
    wr(3'd1, 8'd4);
    wr(3'd4, 8'h14);
    wait_rise(0);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'd9;
    hi = 0;
    while (pulse_out[0]) begin hi++; @(negedge clk); wr_en = 1'b0; end
    check("R8 current high keeps old width", hi, 5);
    lo = 0;
    while (!pulse_out[0]) begin lo++; @(negedge clk); end
    check("R8 low", lo, 3);
    hi = 0;
    while (pulse_out[0]) begin hi++; @(negedge clk); end
    check("R8 next high uses new width", hi, 10);
    wr(3'd4, 8'h00);

    // R7: flag rises on the edge where the pin falls; clear works
    wr(3'd6, 8'h03);
    check("R7 flags cleared", irq_flag, 0);
    wr(3'd0, 8'd3);
    wr(3'd1, 8'd3);
    wr(3'd4, 8'h14);
    wait_rise(0);
    wr(3'd6, 8'h01);
    check("R7 clear inside high", irq_flag[0], 0);
    prev = irq_flag[0];
    while (pulse_out[0]) begin prev = irq_flag[0]; @(negedge clk); end
    check("R7 flag before fall", prev, 0);
    check("R7 flag at fall", irq_flag[0], 1);
    wr(3'd4, 8'h00);

    // R9: output disabled, counting continues
    wr(3'd6, 8'h03);
    wr(3'd2, 8'd3);
    wr(3'd3, 8'd3);
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h08);
    count_high(1, 60, n);
    check("R9 disabled pin quiet", n, 0);
    check("R9 flag still set", irq_flag[1], 1);
    wr(3'd4, 8'h00);

    // R5: wide mode
    wr(3'd6, 8'h03);
    wr(3'd0, 8'd4);
    wr(3'd2, 8'd1);
    wr(3'd1, 8'd2);
    wr(3'd3, 8'd0);
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h3D);
    measure(1, hi, lo);
    check("R5 wide high", hi, 3);
    check("R5 wide low", lo, 261);
    count_high(0, 300, n);
    check("R5 pin0 quiet", n, 0);
    check("R5 flag0 clear", irq_flag[0], 0);
    check("R5 flag1 set", irq_flag[1], 1);
    wr(3'd4, 8'h00);

    // R6: chained mode, channel 0 prescales channel 1
    wr(3'd0, 8'd2);
    wr(3'd1, 8'd2);
    wr(3'd2, 8'd1);
    wr(3'd3, 8'd3);
    wr(3'd5, 8'h51);
    wr(3'd4, 8'h3E);
    measure(1, hi, lo);
    check("R6 chain high", hi, 4 * span(2, 1));
    check("R6 chain low", lo, 2 * span(2, 1));
    measure(0, hi, lo);
    check("R6 prescaler high", hi, span(2, 1));
    check("R6 prescaler low", lo, span(2, 1));

    // R10: clearing run drops the pin
    wait_rise(1);
    wr(3'd4, 8'h22);
    @(negedge clk);
    count_high(1, 60, n);
    check("R10 stopped pin low", n, 0);

    finish_run();
  end

endmodule